// File: doc/BRIEF.md
# ADC Conversion Result Register Block

This block joins a 10-bit successive-approximation converter core to an 8-bit processor bus. Each finished conversion is written into two byte-wide data registers. The result is packed toward the bottom of the 16 bits by default, or toward the top when software asks for left alignment. When it is packed toward the top and 8 bits of precision are enough, software can read the high byte alone.

Reading a full result takes two bus reads: the low byte first, then the high byte. The low-byte read freezes both data registers so that the two bytes always come from the same conversion. The high-byte read unfreezes them. A conversion that finishes while the registers are frozen is thrown away, but it still raises the conversion-complete flag. That flag is cleared by writing one to it and drives the interrupt output when the interrupt is enabled.

A master enable bit gates the core. While it is clear, no conversion start reaches the core and the channel and reference selections presented to the core stay frozen.

Top module: `adc_result_regs`

## Requirements
- R1: After reset the two data bytes read 0, the data registers are unlocked, and the enable, left-align, interrupt-enable and flag bits all read 0. The irq output is low.
- R2: With the left-align bit (control register, address 2, bit 1) clear, a captured result r reads as high byte (address 1) = {6'b0, r[9:8]} and low byte (address 0) = r[7:0].
- R3: With the left-align bit set, a captured result r reads as high byte = r[9:2] and low byte = {r[1:0], 6'b0}.
- R4: Changing the left-align bit does not reformat a result already held; it applies from the next captured result.
- R5: A bus read of the low byte locks both data bytes. A conversion done that arrives while they are locked, or in the same cycle as the low-byte read, changes neither byte.
- R6: A bus read of the high byte releases the lock, so the next conversion done is captured.
- R7: Reading the high byte without a prior low-byte read never engages the lock.
- R8: The flag (control bit 3) is set by every conversion done, including one that the lock discarded. Writing 1 to bit 3 clears it. If a done and a clearing write fall in the same cycle, the set wins.
- R9: The irq output equals the flag ANDed with the interrupt-enable bit (control bit 2).
- R10: A write to the control register with bit 4 (start) and bit 0 (enable) both 1 produces a one-cycle convStart pulse in the next cycle. A write with start set but enable clear produces no pulse. Bit 4 always reads as 0.
- R11: The selection register (address 3: channel in bits 4:0, reference in bits 7:5) reads back as written. The chanSel and refSel outputs take its value only while the enable bit is set, and hold their value while the enable bit is clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | 2 | Register address: 0 low byte, 1 high byte, 2 control, 3 selection |
| busWrEn | input | 1 | Write strobe |
| busRdEn | input | 1 | Read strobe (read side effects act at the clock edge) |
| busWrData | input | 8 | Write data |
| busRdData | output | 8 | Read data for busAddr (combinational) |
| convDone | input | 1 | One-cycle pulse from the core when a conversion finishes |
| convResult | input | 10 | Conversion result, valid with convDone |
| convStart | output | 1 | One-cycle conversion start request to the core |
| chanSel | output | 5 | Channel selection presented to the core |
| refSel | output | 3 | Reference selection presented to the core |
| irq | output | 1 | Conversion-complete interrupt |

## Verification
Every one of the 1024 result codes is captured and read back under right alignment and again under left alignment. This separates errors in bit placement, zero fill and truncation at each bit position. Each capture in the sweep is read in low-then-high order, so every code also passes through lock and release. Directed sequences then separate the orderings that matter: a done while locked, a done in the same cycle as a low-byte read, a high-only read, an alignment change with data already held, and a flag clear in the same cycle as a done. Start and selection gating are tried with enable both clear and set.

// File: rtl/adc_result_pkg.sv
package adc_result_pkg;
  parameter int RES_W  = 10;
  parameter int BUS_W  = 8;
  parameter int ADDR_W = 2;
  parameter int CHAN_W = 5;
  parameter int REF_W  = 3;

  localparam logic [ADDR_W-1:0] ADDR_LO   = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_HI   = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_CTRL = 2'd2;
  localparam logic [ADDR_W-1:0] ADDR_SEL  = 2'd3;

  localparam int BIT_EN    = 0;
  localparam int BIT_LEFT  = 1;
  localparam int BIT_IRQEN = 2;
  localparam int BIT_FLAG  = 3;
  localparam int BIT_START = 4;

  typedef struct packed {
    logic captureEn;
    logic leftAlign;
  } ctrlStrobes_t;
endpackage

// File: rtl/adc_result_dp.sv
module adc_result_dp
  import adc_result_pkg::*;
#(
  parameter int RW = RES_W,
  parameter int BW = BUS_W
) (
  input  logic          clk,
  input  logic          rstN,
  input  ctrlStrobes_t  strobes,
  input  logic [RW-1:0] result,
  output logic [BW-1:0] loByte,
  output logic [BW-1:0] hiByte
);
  localparam int FULL_W = 2 * BW;
  localparam int PAD_W  = FULL_W - RW;

  logic [FULL_W-1:0] packedRight;
  logic [FULL_W-1:0] packedLeft;
  logic [FULL_W-1:0] packedSel;
  logic [FULL_W-1:0] heldWord;

  always_comb begin
    packedRight = {{PAD_W{1'b0}}, result};
    packedLeft  = {result, {PAD_W{1'b0}}};
    packedSel   = strobes.leftAlign ? packedLeft : packedRight;
  end

  for (genvar b = 0; b < 2; b++) begin : g_byte
    always_ff @(posedge clk) begin
      if (!rstN)
        heldWord[b*BW +: BW] <= '0;
      else if (strobes.captureEn)
        heldWord[b*BW +: BW] <= packedSel[b*BW +: BW];
    end
  end

  assign loByte = heldWord[BW-1:0];
  assign hiByte = heldWord[FULL_W-1:BW];
endmodule

// File: rtl/adc_result_ctrl.sv
module adc_result_ctrl
  import adc_result_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic              busRdEn,
  input  logic [BUS_W-1:0]  busWrData,
  input  logic              convDone,
  output ctrlStrobes_t      strobes,
  output logic              lockActive,
  output logic              ctrlEnable,
  output logic              leftAlign,
  output logic              intEnable,
  output logic              intFlag,
  output logic              convStart,
  output logic [CHAN_W-1:0] chanShadow,
  output logic [REF_W-1:0]  refShadow,
  output logic [CHAN_W-1:0] chanSel,
  output logic [REF_W-1:0]  refSel
);
  logic rdLo, rdHi, wrCtrl, wrSel;

  always_comb begin
    rdLo   = busRdEn && (busAddr == ADDR_LO);
    rdHi   = busRdEn && (busAddr == ADDR_HI);
    wrCtrl = busWrEn && (busAddr == ADDR_CTRL);
    wrSel  = busWrEn && (busAddr == ADDR_SEL);
    strobes.captureEn = convDone && !lockActive && !rdLo;
    strobes.leftAlign = leftAlign;
  end

  always_ff @(posedge clk) begin
    if (!rstN)      lockActive <= 1'b0;
    else if (rdLo)  lockActive <= 1'b1;
    else if (rdHi)  lockActive <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctrlEnable <= 1'b0;
      leftAlign  <= 1'b0;
      intEnable  <= 1'b0;
    end else if (wrCtrl) begin
      ctrlEnable <= busWrData[BIT_EN];
      leftAlign  <= busWrData[BIT_LEFT];
      intEnable  <= busWrData[BIT_IRQEN];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)                              intFlag <= 1'b0;
    else if (convDone)                      intFlag <= 1'b1;
    else if (wrCtrl && busWrData[BIT_FLAG]) intFlag <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rstN) convStart <= 1'b0;
    else       convStart <= wrCtrl && busWrData[BIT_START] && busWrData[BIT_EN];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      chanShadow <= '0;
      refShadow  <= '0;
    end else if (wrSel) begin
      chanShadow <= busWrData[CHAN_W-1:0];
      refShadow  <= busWrData[BUS_W-1 -: REF_W];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      chanSel <= '0;
      refSel  <= '0;
    end else if (ctrlEnable) begin
      chanSel <= chanShadow;
      refSel  <= refShadow;
    end
  end
endmodule

// File: rtl/adc_result_regs.sv
module adc_result_regs
  import adc_result_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic              busRdEn,
  input  logic [BUS_W-1:0]  busWrData,
  output logic [BUS_W-1:0]  busRdData,
  input  logic              convDone,
  input  logic [RES_W-1:0]  convResult,
  output logic              convStart,
  output logic [CHAN_W-1:0] chanSel,
  output logic [REF_W-1:0]  refSel,
  output logic              irq
);
  localparam int SEL_GAP = BUS_W - CHAN_W - REF_W;

  ctrlStrobes_t      strobes;
  logic              lockActive, ctrlEnable, leftAlign, intEnable, intFlag;
  logic [CHAN_W-1:0] chanShadow;
  logic [REF_W-1:0]  refShadow;
  logic [BUS_W-1:0]  loByte, hiByte;

  adc_result_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
    .busRdEn(busRdEn), .busWrData(busWrData), .convDone(convDone),
    .strobes(strobes), .lockActive(lockActive), .ctrlEnable(ctrlEnable),
    .leftAlign(leftAlign), .intEnable(intEnable), .intFlag(intFlag),
    .convStart(convStart), .chanShadow(chanShadow), .refShadow(refShadow),
    .chanSel(chanSel), .refSel(refSel)
  );

  adc_result_dp u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .result(convResult),
    .loByte(loByte), .hiByte(hiByte)
  );

  always_comb begin
    busRdData = '0;
    case (busAddr)
      ADDR_LO: busRdData = loByte;
      ADDR_HI: busRdData = hiByte;
      ADDR_CTRL: begin
        busRdData[BIT_EN]    = ctrlEnable;
        busRdData[BIT_LEFT]  = leftAlign;
        busRdData[BIT_IRQEN] = intEnable;
        busRdData[BIT_FLAG]  = intFlag;
      end
      default: busRdData = {refShadow, {SEL_GAP{1'b0}}, chanShadow};
    endcase
  end

  assign irq = intFlag && intEnable;
endmodule

// File: rtl/adc_result_chk.sv
module adc_result_chk
  import adc_result_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] busAddr,
  input logic              busRdEn,
  input logic              convDone,
  input logic              convStart,
  input logic              lockActive,
  input logic              ctrlEnable,
  input logic              intFlag,
  input logic [BUS_W-1:0]  loByte,
  input logic [BUS_W-1:0]  hiByte,
  input logic [CHAN_W-1:0] chanSel,
  input logic [REF_W-1:0]  refSel
);
  AST_LOCK_FREEZES: assert property (@(posedge clk) disable iff (!rstN)
    lockActive |=> $stable(loByte) && $stable(hiByte)); // R5

  AST_HI_ONLY_NO_LOCK: assert property (@(posedge clk) disable iff (!rstN)
    !lockActive && busRdEn && busAddr == ADDR_HI |=> !lockActive); // R7

  AST_DONE_SETS_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    convDone |=> intFlag); // R8

  AST_START_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    convStart |=> !convStart); // R10

  AST_START_NEEDS_EN: assert property (@(posedge clk) disable iff (!rstN)
    convStart |-> ctrlEnable); // R10

  AST_SEL_HELD: assert property (@(posedge clk) disable iff (!rstN)
    !ctrlEnable |=> $stable(chanSel) && $stable(refSel)); // R11
endmodule

bind adc_result_regs adc_result_chk u_chk (
  .clk(clk), .rstN(rstN), .busAddr(busAddr), .busRdEn(busRdEn),
  .convDone(convDone), .convStart(convStart), .lockActive(lockActive),
  .ctrlEnable(ctrlEnable), .intFlag(intFlag), .loByte(loByte),
  .hiByte(hiByte), .chanSel(chanSel), .refSel(refSel)
);

// File: tb/adc_result_regs_tb.sv
`timescale 1ns/1ps
module adc_result_regs_tb;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [1:0] busAddr = '0;
  logic       busWrEn = 1'b0, busRdEn = 1'b0;
  logic [7:0] busWrData = '0;
  logic [7:0] busRdData;
  logic       convDone = 1'b0;
  logic [9:0] convResult = '0;
  logic       convStart;
  logic [4:0] chanSel;
  logic [2:0] refSel;
  logic       irq;

  int vecCount = 0;
  int errCount = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  adc_result_regs u_dut (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
    .busRdEn(busRdEn), .busWrData(busWrData), .busRdData(busRdData),
    .convDone(convDone), .convResult(convResult), .convStart(convStart),
    .chanSel(chanSel), .refSel(refSel), .irq(irq)
  );

  task automatic check(input string req, input int act, input int exp);
    vecCount++;
    if (act !== exp) begin
      errCount++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic busWrite(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    busAddr = a; busWrData = d; busWrEn = 1'b1;
    @(negedge clk);
    busWrEn = 1'b0;
  endtask

  task automatic busRead(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    busAddr = a; busRdEn = 1'b1;
    #1 d = busRdData;
    @(negedge clk);
    busRdEn = 1'b0;
  endtask

  task automatic doneOnce(input logic [9:0] r);
    @(negedge clk);
    convDone = 1'b1; convResult = r;
    @(negedge clk);
    convDone = 1'b0;
  endtask

  function automatic logic [15:0] packExp(input logic [9:0] r, input bit left);
    return left ? {r, 6'b0} : {6'b0, r};
  endfunction

  task automatic readPair(output logic [15:0] w);
    logic [7:0] lo, hi;
    busRead(2'd0, lo);
    busRead(2'd1, hi);
    w = {hi, lo};
  endtask

  initial begin
    logic [7:0]  d;
    logic [15:0] w;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    busRead(2'd0, d); check("R1 lo", d, 0);
    busRead(2'd1, d); check("R1 hi", d, 0);
    busRead(2'd2, d); check("R1 ctrl", d, 0);
    check("R1 irq", irq, 0);
    doneOnce(10'h2A5);
    readPair(w); check("R1 unlocked after reset", w, packExp(10'h2A5, 0));

    // R2/R3 sweeps, R6 release per pair, R8 flag per done
    for (int m = 0; m < 2; m++) begin
      busWrite(2'd2, m ? 8'h0A : 8'h08);
      for (int v = 0; v < 1024; v++) begin
        doneOnce(v[9:0]);
        busRead(2'd2, d); check("R8 flag set", d[3], 1);
        busWrite(2'd2, m ? 8'h0A : 8'h08);
        readPair(w);
        check(m ? "R3 left align" : "R2 right align", w, packExp(v[9:0], m[0]));
      end
    end

    // R4 alignment change keeps held data
    busWrite(2'd2, 8'h08);
    doneOnce(10'h1C3);
    busWrite(2'd2, 8'h02);
    readPair(w); check("R4 held not reformatted", w, packExp(10'h1C3, 0));
    doneOnce(10'h1C3);
    readPair(w); check("R4 next capture left", w, packExp(10'h1C3, 1));
    busWrite(2'd2, 8'h08);

    // R5 done while locked is dropped, R8 flag still set
    doneOnce(10'h155);
    busRead(2'd0, d); check("R5 lo before lock", d, 8'h55);
    doneOnce(10'h2AA);
    busRead(2'd2, d); check("R8 flag on dropped", d[3], 1);
    busRead(2'd0, d); check("R5 lo frozen", d, 8'h55);
    busRead(2'd1, d); check("R5 hi frozen", d, 8'h01);
    // R6 released
    doneOnce(10'h2AA);
    readPair(w); check("R6 capture after release", w, packExp(10'h2AA, 0));

    // R5 done in same cycle as low read
    @(negedge clk);
    busAddr = 2'd0; busRdEn = 1'b1; convDone = 1'b1; convResult = 10'h0F0;
    @(negedge clk);
    busRdEn = 1'b0; convDone = 1'b0;
    busRead(2'd1, d); check("R5 same-cycle hi", d, 8'h02);
    busRead(2'd0, d); check("R5 same-cycle lo", d, 8'hAA);
    busRead(2'd1, d);

    // R7 high-only read does not lock
    busRead(2'd1, d);
    doneOnce(10'h333);
    readPair(w); check("R7 hi-only no lock", w, packExp(10'h333, 0));

    // R8 set wins over same-cycle clear; W1C clears
    busWrite(2'd2, 8'h08);
    @(negedge clk);
    busAddr = 2'd2; busWrData = 8'h08; busWrEn = 1'b1; convDone = 1'b1;
    @(negedge clk);
    busWrEn = 1'b0; convDone = 1'b0;
    busRead(2'd2, d); check("R8 set wins", d[3], 1);
    busWrite(2'd2, 8'h08);
    busRead(2'd2, d); check("R8 w1c", d[3], 0);

    // R9 irq gating
    doneOnce(10'h001);
    #1 check("R9 irq masked", irq, 0);
    busWrite(2'd2, 8'h04);
    #1 check("R9 irq enabled", irq, 1);
    busWrite(2'd2, 8'h0C);
    #1 check("R9 irq cleared", irq, 0);

    // R10 start gating
    busWrite(2'd2, 8'h10);
    #1 check("R10 no start when disabled", convStart, 0);
    busWrite(2'd2, 8'h11);
    #1 check("R10 start pulse", convStart, 1);
    @(negedge clk); #1 check("R10 pulse one cycle", convStart, 0);
    busRead(2'd2, d); check("R10 start reads 0", d[4], 0);

    // R11 selection gating
    busWrite(2'd2, 8'h00);
    busWrite(2'd3, 8'hB6);
    busRead(2'd3, d); check("R11 readback", d, 8'hB6);
    repeat (2) @(negedge clk);
    #1 check("R11 chan held", chanSel, 0);
    check("R11 ref held", refSel, 0);
    busWrite(2'd2, 8'h01);
    @(negedge clk);
    #1 check("R11 chan applied", chanSel, 5'h16);
    check("R11 ref applied", refSel, 3'h5);
    busWrite(2'd2, 8'h00);
    busWrite(2'd3, 8'h21);
    repeat (2) @(negedge clk);
    #1 check("R11 chan hold after disable", chanSel, 5'h16);

    finished = 1'b1;
  end

  initial begin
    fork
      wait (finished);
      begin
        repeat (150000) @(posedge clk);
        errCount++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", vecCount, errCount);
    $finish;
  end
endmodule